// File: doc/BRIEF.md
# Sliced Magnitude Comparator with Output Enable

The block takes two unsigned operands and tells which one is larger, or that they match, on three mutually exclusive flags. The operands are split into equal slices (two 4-bit slices by default, making an 8-bit compare). Each slice works out its own equal, greater and less results. A merge stage then walks the slices from the most significant one downward, so the first slice whose operands differ decides the answer.

An enable input qualifies the result. When the enable is low, all three flags read 0. By default the flags are registered once for timing, so a result appears one clock after its operands. A parameter removes that register and leaves a purely combinational path.

Top module: `mag_cmp`

## Requirements
- R1: With the enable high and a_i equal to b_i, eq_o is 1 and gt_o and lt_o are 0.
- R2: With the enable high and a_i greater than b_i as unsigned numbers, gt_o is 1 and eq_o and lt_o are 0.
- R3: With the enable high and a_i less than b_i as unsigned numbers, lt_o is 1 and eq_o and gt_o are 0.
- R4: With en_i low, eq_o, gt_o and lt_o are all 0, whatever the operands are.
- R5: With the enable high, exactly one of eq_o, gt_o and lt_o is 1 for every operand pair.
- R6: When the upper slices (bits 7:4) of the operands differ, they alone decide gt_o and lt_o, whatever the lower bits hold.
- R7: When the upper slices are equal, the lower slice (bits 3:0) decides the result.
- R8: While rst_ni is low, all three outputs are 0. The reset is asynchronous.
- R9: With the default registered output, each result reflects the operands and enable sampled at the previous rising clock edge, and it does not change between edges.
- R10: Inside every slice, the equal result built from per-bit XNOR matches the result "neither greater nor less".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | First unsigned operand |
| b_i | input | 8 | Second unsigned operand |
| en_i | input | 1 | Output enable; when low, all flags are 0 |
| eq_o | output | 1 | a_i equals b_i |
| gt_o | output | 1 | a_i is greater than b_i |
| lt_o | output | 1 | a_i is less than b_i |

## Verification
Every flag is due exactly one rising edge after its operands and enable are sampled. The bench changes the inputs on the falling edge and reads the outputs on the next falling edge, half a period after the capturing edge. It then compares them with a value it computed from the integers it applied one edge earlier. A separate check reads the outputs before the capturing edge, to confirm that they still hold the previous result. A further check pulls reset low between edges and confirms that the flags clear without waiting for a clock.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef struct packed {
    logic eq;
    logic gt;
    logic lt;
  } cmp_res_t;

  localparam cmp_res_t CMP_NONE = '{eq: 1'b0, gt: 1'b0, lt: 1'b0};
endpackage

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output cmp_res_t     res_o
);
  logic [W-1:0] same;
  logic         gt, lt, done;

  assign same = ~(a_i ^ b_i);

  // the most significant differing bit decides
  always_comb begin
    gt   = 1'b0;
    lt   = 1'b0;
    done = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!done && !same[i]) begin
        gt   = a_i[i];
        lt   = b_i[i];
        done = 1'b1;
      end
    end
  end

  assign res_o.eq = &same;
  assign res_o.gt = gt;
  assign res_o.lt = lt;
endmodule

// File: rtl/mag_cmp_merge.sv
module mag_cmp_merge
  import mag_cmp_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 2
) (
  input  cmp_res_t [NUM_SLICES-1:0] slc_i,
  input  logic                      en_i,
  output cmp_res_t                  res_o
);
  logic g, l, e;

  // walk from the top slice; lower slices count only while everything above is equal
  always_comb begin
    g = 1'b0;
    l = 1'b0;
    e = 1'b1;
    for (int i = NUM_SLICES - 1; i >= 0; i--) begin
      g = g | (e & slc_i[i].gt);
      l = l | (e & slc_i[i].lt);
      e = e & slc_i[i].eq;
    end
  end

  always_comb begin
    res_o = CMP_NONE;
    if (en_i) begin
      res_o.eq = e;
      res_o.gt = g;
      res_o.lt = l;
    end
  end
endmodule

// File: rtl/mag_cmp.sv
module mag_cmp
  import mag_cmp_pkg::*;
#(
  parameter int unsigned SLICE_W    = 4,
  parameter int unsigned NUM_SLICES = 2,
  parameter bit          REG_OUT    = 1'b1,
  localparam int unsigned DATA_W    = SLICE_W * NUM_SLICES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              en_i,
  output logic              eq_o,
  output logic              gt_o,
  output logic              lt_o
);
  cmp_res_t [NUM_SLICES-1:0] slc_res;
  logic     [NUM_SLICES-1:0] slc_eq, slc_gt, slc_lt;
  cmp_res_t                  merged;
  cmp_res_t                  out_res;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    mag_cmp_slice #(.W(SLICE_W)) u_slice (
      .a_i  (a_i[s*SLICE_W +: SLICE_W]),
      .b_i  (b_i[s*SLICE_W +: SLICE_W]),
      .res_o(slc_res[s])
    );
    assign slc_eq[s] = slc_res[s].eq;
    assign slc_gt[s] = slc_res[s].gt;
    assign slc_lt[s] = slc_res[s].lt;
  end

  mag_cmp_merge #(.NUM_SLICES(NUM_SLICES)) u_merge (
    .slc_i(slc_res),
    .en_i (en_i),
    .res_o(merged)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_res <= CMP_NONE;
      else         out_res <= merged;
    end
  end else begin : g_comb
    assign out_res = merged;
  end

  assign eq_o = out_res.eq;
  assign gt_o = out_res.gt;
  assign lt_o = out_res.lt;
endmodule

// File: rtl/mag_cmp_chk.sv
module mag_cmp_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_SLICES = 2,
  parameter bit          REG_OUT    = 1'b1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [DATA_W-1:0]     a_i,
  input logic [DATA_W-1:0]     b_i,
  input logic                  en_i,
  input logic                  eq_o,
  input logic                  gt_o,
  input logic                  lt_o,
  input logic [NUM_SLICES-1:0] slc_eq,
  input logic [NUM_SLICES-1:0] slc_gt,
  input logic [NUM_SLICES-1:0] slc_lt
);
  // R10: xnor-based equality agrees with "neither greater nor less"
  a_r10_slice_eq_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slc_eq == ~(slc_gt | slc_lt));

  if (REG_OUT) begin : g_seq
    a_r1_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && a_i == b_i) |=> (eq_o && !gt_o && !lt_o));
    a_r2_greater: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && a_i > b_i) |=> (gt_o && !eq_o && !lt_o));
    a_r3_less: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && a_i < b_i) |=> (lt_o && !eq_o && !gt_o));
    a_r4_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!eq_o && !gt_o && !lt_o));
    a_r5_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> ($countones({eq_o, gt_o, lt_o}) == 1));
  end else begin : g_comb
    a_r1_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && a_i == b_i) |-> (eq_o && !gt_o && !lt_o));
    a_r2_greater: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && a_i > b_i) |-> (gt_o && !eq_o && !lt_o));
    a_r3_less: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && a_i < b_i) |-> (lt_o && !eq_o && !gt_o));
    a_r4_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |-> (!eq_o && !gt_o && !lt_o));
    a_r5_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |-> ($countones({eq_o, gt_o, lt_o}) == 1));
  end
endmodule

bind mag_cmp mag_cmp_chk #(
  .DATA_W    (DATA_W),
  .NUM_SLICES(NUM_SLICES),
  .REG_OUT   (REG_OUT)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .a_i   (a_i),
  .b_i   (b_i),
  .en_i  (en_i),
  .eq_o  (eq_o),
  .gt_o  (gt_o),
  .lt_o  (lt_o),
  .slc_eq(slc_eq),
  .slc_gt(slc_gt),
  .slc_lt(slc_lt)
);

// File: tb/mag_cmp_test.sv
module mag_cmp_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a_i = '0, b_i = '0;
  logic       en_i = 1'b0;
  logic       eq_o, gt_o, lt_o;

  int total = 0;
  int bad   = 0;

  mag_cmp uut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (a_i),
    .b_i   (b_i),
    .en_i  (en_i),
    .eq_o  (eq_o),
    .gt_o  (gt_o),
    .lt_o  (lt_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [2:0] model(int a, int b, bit en);
    if (!en) return 3'b000;
    return {a == b, a > b, a < b};
  endfunction

  task automatic check(string req, logic [2:0] exp);
    total++;
    if ({eq_o, gt_o, lt_o} !== exp) begin
      bad++;
      $display("FAIL %s: {eq,gt,lt} actual=%b expected=%b (a=%0d b=%0d en=%0b)",
               req, {eq_o, gt_o, lt_o}, exp, a_i, b_i, en_i);
    end
  endtask

  // drive on falling edge, capture at rising edge, check on next falling edge
  task automatic apply(string req, int a, int b, bit en);
    @(negedge clk_i);
    a_i  = 8'(a);
    b_i  = 8'(b);
    en_i = en;
    @(negedge clk_i);
    check(req, model(a, b, en));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8: outputs clear while in reset, with hot inputs
    a_i  = 8'd9;
    b_i  = 8'd3;
    en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R8", 3'b000);
    rst_ni = 1'b1;

    apply("R1", 8'h5A, 8'h5A, 1'b1);
    apply("R1", 0, 0, 1'b1);
    apply("R1", 255, 255, 1'b1);
    apply("R2", 200, 17, 1'b1);
    apply("R2", 255, 254, 1'b1);
    apply("R3", 0, 1, 1'b1);
    apply("R3", 127, 128, 1'b1);
    // R6: upper nibble dominates opposite lower nibble
    apply("R6", 8'h20, 8'h1F, 1'b1);
    apply("R6", 8'h1F, 8'h20, 1'b1);
    apply("R6", 8'hF0, 8'hEF, 1'b1);
    // R7: upper equal, lower decides
    apply("R7", 8'h39, 8'h38, 1'b1);
    apply("R7", 8'h70, 8'h7F, 1'b1);
    // R4: disabled flags stay low
    apply("R4", 8'hAA, 8'hAA, 1'b0);
    apply("R4", 255, 0, 1'b0);
    apply("R4", 0, 255, 1'b0);

    // R9: registered result holds until the capturing edge
    apply("R9", 100, 50, 1'b1);
    @(negedge clk_i);
    a_i = 8'd10;
    b_i = 8'd90;
    #(CLK_PERIOD/4);
    check("R9", 3'b010);
    @(negedge clk_i);
    check("R9", 3'b001);

    // R5: exhaustive-ish sweep against the model
    for (int i = 0; i < 600; i++) begin
      int a = int'($urandom_range(0, 255));
      int b = (i % 5 == 0) ? a : int'($urandom_range(0, 255));
      bit e = (i % 7 != 0);
      apply("R5", a, b, e);
    end

    // R8: asynchronous reset mid-run clears without a clock edge
    apply("R2", 40, 30, 1'b1);
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    check("R8", 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply("R3", 30, 40, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule